// File: doc/BRIEF.md
# Ethernet Frame Length Guard

This block enforces the largest frame size a MAC may carry, separately for the receive and transmit paths. It holds a small slice of control registers: a configuration word with a jumbo enable and an extended receive-length enable, a programmable jumbo length, a sticky error status word and an interrupt mask. From these it derives one length limit for each direction. A frame-buffer controller asks it for a verdict on every frame.

On receive, the guard sees one strobe for each byte, with start and end markers. It counts the bytes and gives its verdict on the cycle after the last byte. An oversize frame gets a drop pulse, and the downstream store-and-forward buffer throws away the whole frame. On transmit, the guard sees the buffer lengths of a frame one by one. A buffer that would take the running total past the limit ends the frame with an abort pulse. Both errors set the same sticky status bit, which is masked into an interrupt line.

Top module: `frame_len_guard`

## Requirements
- R1: After reset, the configuration register reads 0, the jumbo length register reads JUMBO_CEIL (10240 by default), the status and mask registers read 0, and the outputs rx_ok, rx_drop, tx_done, tx_abort and irq are low.
- R2: With jumbo mode off (configuration bit 3 = 0), the transmit limit is 1518 bytes whatever the value of configuration bit 8.
- R3: With jumbo mode off, the receive limit is 1538 bytes when configuration bit 8 is 1, and 1518 bytes when it is 0.
- R4: With configuration bit 3 = 1, both limits equal the 14-bit jumbo length register at byte address 0x48.
- R5: A jumbo length register value above JUMBO_CEIL reads back unchanged, but the limit in force is JUMBO_CEIL.
- R6: One cycle after the end-marked byte, a receive frame of length N raises rx_ok when N is at most the limit, and raises rx_drop when N is above it. rx_len shows N in both cases, up to the saturation point given in R7.
- R7: The receive byte count saturates at limit+1, so the rx_len of a dropped frame is always limit+1.
- R8: Transmit buffer lengths add up. A buffer that fits, if it is marked last, gives tx_done and tx_len equal to the total one cycle later; a total equal to the limit fits. A buffer that does not fit gives tx_abort one cycle later. The buffers that follow it, up to and including the next last-marked one, produce no output.
- R9: Status bit 6 (address 0x20) is set one cycle after rx_drop or tx_abort. It stays set until written with bit 6 = 1, and a new error in the same cycle as that write wins over the clear. Mask bit 6 is at address 0x28. irq rises one cycle after status and mask are both set.
- R10: A receive limit is fixed at the start of each frame. A configuration write made in the middle of a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears on the following cycle |
| reg_addr | input | ADDR_W | Register byte address (configuration 0x04, status 0x20, mask 0x28, jumbo length 0x48) |
| reg_wdata | input | LEN_W | Register write data |
| reg_rdata | output | LEN_W | Register read data, registered |
| rx_valid | input | 1 | One received byte this cycle |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_ok | output | 1 | Frame accepted pulse |
| rx_drop | output | 1 | Frame over the limit, discard pulse |
| rx_len | output | LEN_W+1 | Counted frame length, saturating at limit+1 |
| tx_desc_valid | input | 1 | Transmit buffer length presented |
| tx_desc_len | input | LEN_W | Buffer length in bytes |
| tx_desc_last | input | 1 | Buffer ends the frame |
| tx_done | output | 1 | Frame assembled within the limit |
| tx_abort | output | 1 | Frame assembly stopped on overflow |
| tx_len | output | LEN_W | Total length of an assembled frame |
| irq | output | 1 | Masked error interrupt |

## Verification
The status bit has three possible inputs in one cycle: a receive drop, a transmit abort and a software write-one-to-clear. The bench creates two of these collisions. In the first, the end byte of an oversize receive frame and an overflowing transmit buffer are sent on the same edge, so both pulses arrive together. In the second, a clearing write is placed on exactly the edge where a new drop sets the status bit. In both cases the status register is read back afterwards and must show the bit still set. A later clearing write with no error beside it must show the bit cleared and irq falling.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int STD_FRAME_LEN  = 1518;
  localparam int LONG_FRAME_LEN = 1538;

  localparam int CFG_JUMBO_BIT = 3;
  localparam int CFG_LONG_BIT  = 8;
  localparam int ERR_BIT       = 6;

  localparam logic [7:0] ADDR_CFG  = 8'h04;
  localparam logic [7:0] ADDR_STAT = 8'h20;
  localparam logic [7:0] ADDR_MASK = 8'h28;
  localparam logic [7:0] ADDR_JMAX = 8'h48;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_BUSY = 2'd1,
    TXS_SKIP = 2'd2
  } tx_state_e;
endpackage

// File: rtl/flg_regs.sv
module flg_regs
  import flg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 14,
  parameter int JUMBO_CEIL = 10240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LEN_W-1:0]  reg_wdata,
  output logic [LEN_W-1:0]  reg_rdata,
  input  logic              err_set,
  output logic              jumbo_en,
  output logic              long_rx_en,
  output logic [LEN_W-1:0]  jumbo_len,
  output logic              irq
);
  logic err_q, mask_q, clr_hit;

  assign clr_hit = reg_we && (reg_addr == ADDR_W'(ADDR_STAT)) && reg_wdata[ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      jumbo_en   <= 1'b0;
      long_rx_en <= 1'b0;
      jumbo_len  <= LEN_W'(JUMBO_CEIL);
      err_q      <= 1'b0;
      mask_q     <= 1'b0;
      irq        <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(ADDR_CFG)) begin
        jumbo_en   <= reg_wdata[CFG_JUMBO_BIT];
        long_rx_en <= reg_wdata[CFG_LONG_BIT];
      end
      if (reg_we && reg_addr == ADDR_W'(ADDR_JMAX))
        jumbo_len <= reg_wdata;
      if (reg_we && reg_addr == ADDR_W'(ADDR_MASK))
        mask_q <= reg_wdata[ERR_BIT];
      err_q <= err_set | (err_q & ~clr_hit);
      irq   <= err_q & mask_q;
      if (reg_re) begin
        reg_rdata <= '0;
        if (reg_addr == ADDR_W'(ADDR_CFG)) begin
          reg_rdata[CFG_JUMBO_BIT] <= jumbo_en;
          reg_rdata[CFG_LONG_BIT]  <= long_rx_en;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
          reg_rdata[ERR_BIT] <= err_q;
        end else if (reg_addr == ADDR_W'(ADDR_MASK)) begin
          reg_rdata[ERR_BIT] <= mask_q;
        end else if (reg_addr == ADDR_W'(ADDR_JMAX)) begin
          reg_rdata <= jumbo_len;
        end
      end
    end
  end

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_q) else $error("error event not latched"); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_hit) |=> err_q) else $error("status lost without clear"); // R9
endmodule

// File: rtl/flg_limit.sv
module flg_limit
  import flg_pkg::*;
#(
  parameter int LEN_W      = 14,
  parameter int JUMBO_CEIL = 10240
) (
  input  logic             jumbo_en,
  input  logic             long_rx_en,
  input  logic [LEN_W-1:0] jumbo_len,
  output logic [LEN_W-1:0] rx_limit,
  output logic [LEN_W-1:0] tx_limit
);
  localparam logic [LEN_W-1:0] CEIL_V = LEN_W'(JUMBO_CEIL);
  localparam logic [LEN_W-1:0] STD_V  = LEN_W'(STD_FRAME_LEN);
  localparam logic [LEN_W-1:0] LONG_V = LEN_W'(LONG_FRAME_LEN);

  logic [LEN_W-1:0] jumbo_eff;

  always_comb begin
    jumbo_eff = (jumbo_len > CEIL_V) ? CEIL_V : jumbo_len;
    if (jumbo_en) begin
      rx_limit = jumbo_eff;
      tx_limit = jumbo_eff;
    end else begin
      rx_limit = long_rx_en ? LONG_V : STD_V;
      tx_limit = STD_V;
    end
  end
endmodule

// File: rtl/flg_rx_check.sv
module flg_rx_check #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] rx_limit,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             rx_ok,
  output logic             rx_drop,
  output logic [LEN_W:0]   rx_len
);
  localparam int CW = LEN_W + 1;

  logic [CW-1:0]    cnt_q, base, nxt, lim_ext;
  logic [LEN_W-1:0] lim_q, cur_lim;
  logic             in_frame_q, beat;

  always_comb begin
    base    = rx_sof ? '0 : cnt_q;
    cur_lim = rx_sof ? rx_limit : lim_q;
    lim_ext = {1'b0, cur_lim};
    nxt     = (base > lim_ext) ? base : base + 1'b1;
    beat    = rx_valid && (rx_sof || in_frame_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      lim_q      <= '0;
      in_frame_q <= 1'b0;
      rx_ok      <= 1'b0;
      rx_drop    <= 1'b0;
      rx_len     <= '0;
    end else begin
      rx_ok   <= 1'b0;
      rx_drop <= 1'b0;
      if (beat) begin
        cnt_q <= nxt;
        lim_q <= cur_lim;
        if (rx_eof) begin
          in_frame_q <= 1'b0;
          rx_len     <= nxt;
          if (nxt > lim_ext) rx_drop <= 1'b1;
          else               rx_ok   <= 1'b1;
        end else begin
          in_frame_q <= 1'b1;
        end
      end
    end
  end

  AST_RX_SAT: assert property (@(posedge clk) disable iff (rst)
    in_frame_q |-> (cnt_q <= {1'b0, lim_q} + 1'b1)) else $error("rx count past saturation"); // R7
  AST_RX_OK_FITS: assert property (@(posedge clk) disable iff (rst)
    rx_ok |-> (rx_len <= {1'b0, lim_q})) else $error("accepted frame over limit"); // R6
  AST_RX_DROP_LEN: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> (rx_len == {1'b0, lim_q} + 1'b1)) else $error("dropped length not saturated"); // R7
  AST_RX_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_ok, rx_drop})) else $error("two rx verdicts"); // R6
endmodule

// File: rtl/flg_tx_check.sv
module flg_tx_check
  import flg_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] tx_limit,
  input  logic             tx_desc_valid,
  input  logic [LEN_W-1:0] tx_desc_len,
  input  logic             tx_desc_last,
  output logic             tx_done,
  output logic             tx_abort,
  output logic [LEN_W-1:0] tx_len
);
  tx_state_e        st_q;
  logic [LEN_W-1:0] acc_q, lim_q, base, cur_lim, room, sum;
  logic             first, fits;

  always_comb begin
    first   = (st_q == TXS_IDLE);
    base    = first ? '0 : acc_q;
    cur_lim = first ? tx_limit : lim_q;
    room    = cur_lim - base;
    fits    = (tx_desc_len <= room);
    sum     = base + tx_desc_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= TXS_IDLE;
      acc_q    <= '0;
      lim_q    <= '0;
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
      tx_len   <= '0;
    end else begin
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
      if (tx_desc_valid) begin
        if (st_q == TXS_SKIP) begin
          if (tx_desc_last) st_q <= TXS_IDLE;
        end else begin
          lim_q <= cur_lim;
          if (fits) begin
            acc_q <= sum;
            if (tx_desc_last) begin
              tx_done <= 1'b1;
              tx_len  <= sum;
              st_q    <= TXS_IDLE;
            end else begin
              st_q <= TXS_BUSY;
            end
          end else begin
            tx_abort <= 1'b1;
            st_q     <= tx_desc_last ? TXS_IDLE : TXS_SKIP;
          end
        end
      end
    end
  end

  AST_TX_FITS: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (tx_len <= lim_q)) else $error("tx frame over limit"); // R8
  AST_TX_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_done, tx_abort})) else $error("two tx verdicts"); // R8
  AST_TX_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == TXS_SKIP) |=> !tx_done) else $error("output while skipping"); // R8
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard #(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 14,
  parameter int JUMBO_CEIL = 10240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LEN_W-1:0]  reg_wdata,
  output logic [LEN_W-1:0]  reg_rdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  output logic              rx_ok,
  output logic              rx_drop,
  output logic [LEN_W:0]    rx_len,
  input  logic              tx_desc_valid,
  input  logic [LEN_W-1:0]  tx_desc_len,
  input  logic              tx_desc_last,
  output logic              tx_done,
  output logic              tx_abort,
  output logic [LEN_W-1:0]  tx_len,
  output logic              irq
);
  logic             jumbo_en, long_rx_en;
  logic [LEN_W-1:0] jumbo_len, rx_limit, tx_limit;

  flg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .JUMBO_CEIL(JUMBO_CEIL)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set(rx_drop | tx_abort),
    .jumbo_en(jumbo_en), .long_rx_en(long_rx_en), .jumbo_len(jumbo_len), .irq(irq)
  );

  flg_limit #(.LEN_W(LEN_W), .JUMBO_CEIL(JUMBO_CEIL)) u_limit (
    .jumbo_en(jumbo_en), .long_rx_en(long_rx_en), .jumbo_len(jumbo_len),
    .rx_limit(rx_limit), .tx_limit(tx_limit)
  );

  flg_rx_check #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst(rst), .rx_limit(rx_limit), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_ok(rx_ok), .rx_drop(rx_drop), .rx_len(rx_len)
  );

  flg_tx_check #(.LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .tx_limit(tx_limit), .tx_desc_valid(tx_desc_valid),
    .tx_desc_len(tx_desc_len), .tx_desc_last(tx_desc_last), .tx_done(tx_done),
    .tx_abort(tx_abort), .tx_len(tx_len)
  );

  AST_LIMIT_CEIL: assert property (@(posedge clk) disable iff (rst)
    jumbo_en |-> (rx_limit <= LEN_W'(JUMBO_CEIL) && tx_limit == rx_limit))
    else $error("jumbo limit above ceiling"); // R5
endmodule

// File: tb/frame_len_guard_tb_top.sv
module frame_len_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 14;
  localparam logic [7:0] A_CFG = 8'h04, A_STAT = 8'h20, A_MASK = 8'h28, A_JMAX = 8'h48;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, reg_re = 0;
  logic [7:0] reg_addr = '0;
  logic [LEN_W-1:0] reg_wdata = '0, reg_rdata;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_ok, rx_drop;
  logic [LEN_W:0] rx_len;
  logic tx_desc_valid = 0, tx_desc_last = 0, tx_done, tx_abort, irq;
  logic [LEN_W-1:0] tx_desc_len = '0, tx_len;

  int nvec = 0, nerr = 0;
  logic done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_len_guard dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_ok(rx_ok), .rx_drop(rx_drop), .rx_len(rx_len),
    .tx_desc_valid(tx_desc_valid), .tx_desc_len(tx_desc_len), .tx_desc_last(tx_desc_last),
    .tx_done(tx_done), .tx_abort(tx_abort), .tx_len(tx_len), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, int d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = LEN_W'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output int d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = int'(reg_rdata);
  endtask

  task automatic rx_bytes(int n, bit sof, bit eof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = sof && (i == 0); rx_eof = eof && (i == n-1);
    end
  endtask

  // full frame; verdict sampled one cycle after the end byte
  task automatic rx_frame(string req, int n, bit exp_ok, int exp_len);
    rx_bytes(n, 1, 1);
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
    check(req, {31'd0, rx_ok}, {31'd0, exp_ok});
    check(req, {31'd0, rx_drop}, {31'd0, !exp_ok});
    check(req, int'(rx_len), exp_len);
  endtask

  task automatic tx_desc(string req, int len, bit last, bit exp_done, bit exp_abort, int exp_len);
    @(negedge clk); tx_desc_valid = 1; tx_desc_len = LEN_W'(len); tx_desc_last = last;
    @(negedge clk); tx_desc_valid = 0; tx_desc_last = 0;
    check(req, {31'd0, tx_done}, {31'd0, exp_done});
    check(req, {31'd0, tx_abort}, {31'd0, exp_abort});
    if (exp_done) check(req, int'(tx_len), exp_len);
  endtask

  task automatic t_reset();
    int d;
    check("R1 outputs", {27'd0, rx_ok, rx_drop, tx_done, tx_abort, irq}, 0);
    rd(A_CFG, d);  check("R1 cfg", d, 0);
    rd(A_JMAX, d); check("R1 jmax", d, 10240);
    rd(A_STAT, d); check("R1 stat", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
  endtask

  task automatic t_standard();
    wr(A_CFG, 0);
    rx_frame("R3 rx 1518 ok", 1518, 1, 1518);
    rx_frame("R3 R6 R7 rx 1519 drop", 1519, 0, 1519);
    tx_desc("R8 tx part", 1000, 0, 0, 0, 0);
    tx_desc("R2 R8 tx exact 1518", 518, 1, 1, 0, 1518);
    tx_desc("R8 tx part", 1000, 0, 0, 0, 0);
    tx_desc("R2 R8 tx 1519 abort", 519, 1, 0, 1, 0);
    wr(A_CFG, 'h100);
    rx_frame("R3 rx 1538 ok", 1538, 1, 1538);
    rx_frame("R3 R7 rx 1545 drop", 1545, 0, 1539);
    tx_desc("R2 tx 1519 abort with bit 8", 1519, 1, 0, 1, 0);
    tx_desc("R2 tx 1518 ok with bit 8", 1518, 1, 1, 0, 1518);
    wr(A_STAT, 'h40);
  endtask

  task automatic t_jumbo();
    wr(A_JMAX, 100); wr(A_CFG, 'h8);
    rx_frame("R4 rx 100 ok", 100, 1, 100);
    rx_frame("R4 rx 101 drop", 101, 0, 101);
    tx_desc("R4 tx part", 60, 0, 0, 0, 0);
    tx_desc("R4 tx 100 ok", 40, 1, 1, 0, 100);
    tx_desc("R4 tx part", 60, 0, 0, 0, 0);
    tx_desc("R4 tx 101 abort", 41, 1, 0, 1, 0);
  endtask

  task automatic t_clamp();
    int d;
    wr(A_JMAX, 12000); rd(A_JMAX, d); check("R5 jmax readback", d, 12000);
    rx_frame("R5 rx 10240 ok", 10240, 1, 10240);
    rx_frame("R5 rx 10241 drop", 10241, 0, 10241);
    tx_desc("R5 tx 10241 abort", 10241, 1, 0, 1, 0);
    tx_desc("R5 tx 10240 ok", 10240, 1, 1, 0, 10240);
  endtask

  task automatic t_midframe();
    wr(A_CFG, 0);
    rx_bytes(500, 1, 0);
    @(negedge clk); rx_valid = 0;
    wr(A_CFG, 'h100);
    rx_bytes(1030, 0, 1);
    @(negedge clk); rx_valid = 0; rx_eof = 0;
    check("R10 old limit kept", {31'd0, rx_drop}, 1);
    check("R10 len", int'(rx_len), 1519);
    rx_frame("R10 new limit next frame", 1530, 1, 1530);
  endtask

  task automatic t_skip();
    wr(A_CFG, 0);
    tx_desc("R8 skip part", 1000, 0, 0, 0, 0);
    tx_desc("R8 overflow mid frame", 600, 0, 0, 1, 0);
    tx_desc("R8 ignored last", 100, 1, 0, 0, 0);
    tx_desc("R8 next frame", 200, 1, 1, 0, 200);
  endtask

  task automatic t_irq();
    int d;
    wr(A_STAT, 'h40); wr(A_MASK, 'h40);
    rd(A_STAT, d); check("R9 cleared", d, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    rx_frame("R9 drop", 1519, 0, 1519);
    @(negedge clk); @(negedge clk);
    check("R9 irq high", {31'd0, irq}, 1);
    // clear write on the very edge a fresh drop sets status
    rx_bytes(1519, 1, 1);
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
    check("R9 collision drop", {31'd0, rx_drop}, 1);
    reg_we = 1; reg_addr = A_STAT; reg_wdata = 'h40;
    @(negedge clk); reg_we = 0;
    rd(A_STAT, d); check("R9 set wins over clear", d, 'h40);
    wr(A_STAT, 'h40);
    rd(A_STAT, d); check("R9 plain clear", d, 0);
    @(negedge clk);
    check("R9 irq falls", {31'd0, irq}, 0);
  endtask

  task automatic t_dual();
    int d;
    wr(A_JMAX, 100); wr(A_CFG, 'h8);
    rx_bytes(100, 1, 0);
    @(negedge clk); rx_valid = 1; rx_sof = 0; rx_eof = 1;
    tx_desc_valid = 1; tx_desc_len = 101; tx_desc_last = 1;
    @(negedge clk); rx_valid = 0; rx_eof = 0; tx_desc_valid = 0; tx_desc_last = 0;
    check("R9 dual rx drop", {31'd0, rx_drop}, 1);
    check("R9 dual tx abort", {31'd0, tx_abort}, 1);
    rd(A_STAT, d); check("R9 dual status", d, 'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_standard();
    t_jumbo();
    t_clamp();
    t_midframe();
    t_skip();
    t_irq();
    t_dual();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk);
        nerr++; nvec++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule